// File: doc/BRIEF.md
# Link Reservation Monitor for Conditional Stores

This block sits beside one processor's memory path. It watches that processor's requests and decides whether a conditional store may write memory. A load-linked request reads a word and records the block address it touched, marking the reservation valid. A later store-conditional reaches memory only if the reservation is still valid and names the same block. Otherwise the store is dropped, no write is issued, and the processor receives a failure code so that software can retry the whole sequence.

The block does not lock the bus or the memory location. It lets the sequence proceed and then checks for interference. The reservation is dropped when a snooped invalidation or foreign write reaches any word of the reserved block, or when the processor switches context. A conditional store consumes the reservation whether it succeeds or fails. Addresses are word addresses. The low `BLK_LG` bits select a word inside a reservation block.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, the reservation is invalid and `rsp_valid_o` and `mem_we_o` are low, so the first store-conditional fails.
- R2: A plain load (op 0) or a load-linked (op 2) returns the memory word at the request address on `rsp_rdata_o`, with `rsp_valid_o` high, one cycle after the request.
- R3: A store-conditional (op 3) to the reserved block with a valid reservation writes memory: `mem_we_o`, `mem_waddr_o` and `mem_wdata_o` appear one cycle later, and `rsp_rdata_o` returns 0 (success).
- R4: A store-conditional whose block differs from the reserved block returns 1 (failure) and leaves `mem_we_o` low.
- R5: A context-switch pulse drops the reservation.
- R6: A snoop to any word of the reserved block (same address bits above `BLK_LG`) drops the reservation. A snoop to another block does not.
- R7: Every store-conditional, whether it passes or fails, drops the reservation, so a second one without a new load-linked fails.
- R8: A snoop hit or a context switch in the same cycle as a store-conditional makes it fail. A snoop to the requested block or a context switch in the same cycle as a load-linked leaves the reservation invalid.
- R9: A plain store (op 1) always writes memory one cycle later and produces no response. Plain loads and stores leave the reservation unchanged.
- R10: A new load-linked replaces the reserved block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_op_i | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr_i | input | AW | Word address of the request |
| req_wdata_i | input | DW | Store data |
| ctx_switch_i | input | 1 | Context-switch pulse |
| snp_valid_i | input | 1 | Snooped invalidation or foreign write |
| snp_addr_i | input | AW | Word address of the snoop |
| mem_raddr_o | output | AW | Read address to memory (combinational from the request) |
| mem_rdata_i | input | DW | Read data from memory, same cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |
| rsp_valid_o | output | 1 | Response valid for load, load-linked and store-conditional |
| rsp_rdata_o | output | DW | Load data, or the store-conditional result (0 pass, 1 fail) |

## Verification
The hardest cases to reach are collisions inside a single cycle: a snoop that hits the reserved block in the same cycle as the store-conditional, and a snoop or context switch that arrives together with the load-linked that would set the reservation. The stimulus task takes the request, snoop and context-switch inputs together, so such collisions can be forced on any chosen cycle. Snoops also hit a different word of the reserved block, to exercise block-granular matching. The bench model recomputes the expected response and write from its own reservation state on every cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_tag_cmp.sv
module llsc_tag_cmp #(
  parameter int unsigned TW = 10
) (
  input  logic [TW-1:0] a_i,
  input  logic [TW-1:0] b_i,
  output logic          eq_o
);
  generate
    if (TW == 0) begin : g_none
      assign eq_o = 1'b1;
    end else begin : g_cmp
      logic [TW-1:0] diff;
      for (genvar i = 0; i < TW; i++) begin : g_bit
        assign diff[i] = a_i[i] ^ b_i[i];
      end
      assign eq_o = ~|diff;
    end
  endgenerate
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
  parameter int unsigned TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,        // load-linked accepted
  input  logic          consume_i,    // store-conditional accepted
  input  logic          ctx_i,
  input  logic          snp_link_hit_i,
  input  logic          snp_req_hit_i,
  input  logic [TW-1:0] tag_i,
  output logic          valid_o,
  output logic [TW-1:0] tag_o
);
  logic          valid_q;
  logic [TW-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (set_i) begin
      valid_q <= ~(ctx_i | snp_req_hit_i);
      tag_q   <= tag_i;
    end else if (consume_i || ctx_i || snp_link_hit_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;

  AST_CTX_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_i |=> !valid_q); // R5
  AST_SC_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !set_i) |=> !valid_q); // R7
  AST_SNOOP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_link_hit_i && !set_i) |=> !valid_q); // R6
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned BLK_LG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          ctx_switch_i,
  input  logic          snp_valid_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  localparam int unsigned TW = AW - BLK_LG;

  llsc_op_e      op;
  logic          is_ld, is_st, is_ll, is_sc;
  logic [TW-1:0] req_tag, snp_tag, link_tag;
  logic          link_valid;
  logic          sc_eq, snp_link_eq, snp_req_eq;
  logic          snp_link_hit, snp_req_hit, kill_now, sc_pass;

  assign op      = llsc_op_e'(req_op_i);
  assign is_ld   = req_valid_i && (op == OP_LOAD);
  assign is_st   = req_valid_i && (op == OP_STORE);
  assign is_ll   = req_valid_i && (op == OP_LL);
  assign is_sc   = req_valid_i && (op == OP_SC);
  assign req_tag = req_addr_i[AW-1:BLK_LG];
  assign snp_tag = snp_addr_i[AW-1:BLK_LG];

  llsc_tag_cmp #(.TW(TW)) u_cmp_sc (.a_i(req_tag), .b_i(link_tag), .eq_o(sc_eq));
  llsc_tag_cmp #(.TW(TW)) u_cmp_snp_link (.a_i(snp_tag), .b_i(link_tag), .eq_o(snp_link_eq));
  llsc_tag_cmp #(.TW(TW)) u_cmp_snp_req (.a_i(snp_tag), .b_i(req_tag), .eq_o(snp_req_eq));

  assign snp_link_hit = snp_valid_i && snp_link_eq;
  assign snp_req_hit  = snp_valid_i && snp_req_eq;
  assign kill_now     = ctx_switch_i || snp_link_hit;
  assign sc_pass      = is_sc && link_valid && sc_eq && !kill_now;

  llsc_link_reg #(.TW(TW)) u_link (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .set_i          (is_ll),
    .consume_i      (is_sc),
    .ctx_i          (ctx_switch_i),
    .snp_link_hit_i (snp_link_hit),
    .snp_req_hit_i  (snp_req_hit),
    .tag_i          (req_tag),
    .valid_o        (link_valid),
    .tag_o          (link_tag)
  );

  assign mem_raddr_o = req_addr_i;

  logic          rsp_valid_q, rsp_sc_q, mem_we_q;
  logic [DW-1:0] rsp_data_q, wdata_q;
  logic [AW-1:0] waddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_sc_q    <= 1'b0;
      rsp_data_q  <= '0;
      mem_we_q    <= 1'b0;
      waddr_q     <= '0;
      wdata_q     <= '0;
    end else begin
      rsp_valid_q <= is_ld || is_ll || is_sc;
      rsp_sc_q    <= is_sc;
      if (is_sc)             rsp_data_q <= {{(DW-1){1'b0}}, ~sc_pass};
      else if (is_ld || is_ll) rsp_data_q <= mem_rdata_i;
      mem_we_q    <= is_st || sc_pass;
      if (is_st || is_sc) begin
        waddr_q <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign mem_we_o    = mem_we_q;
  assign mem_waddr_o = waddr_q;
  assign mem_wdata_o = wdata_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_q && rsp_sc_q && rsp_data_q[0]) |-> !mem_we_q); // R4
  AST_SC_WRITE_IS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_q && rsp_sc_q && rsp_valid_q) |-> (rsp_data_q == '0)); // R3
  AST_SC_NEEDS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && !link_valid) |=> (rsp_data_q[0] && !mem_we_q)); // R1
  AST_STORE_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_st |=> (mem_we_q && !rsp_valid_q)); // R9
endmodule

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ctx = 1'b0;
  logic          snp_v = 1'b0;
  logic [AW-1:0] snp_a = '0;
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;

  logic [DW-1:0] mem [64];
  int checks = 0;
  int fails  = 0;
  int m_lv = 0;
  int m_lt = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_raddr[5:0]];
  always @(posedge clk) if (mem_we) mem[mem_waddr[5:0]] <= mem_wdata;

  llsc_monitor #(.AW(AW), .DW(DW), .BLK_LG(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ctx_switch_i(ctx),
    .snp_valid_i(snp_v), .snp_addr_i(snp_a), .mem_raddr_o(mem_raddr),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata));

  // op: -1 idle, 0 load, 1 store, 2 load-linked, 3 store-conditional
  task automatic step(input string rq, input int op, input int a, input int wd,
                      input bit sv, input int sa, input bit cx);
    bit e_rv, e_we, pass, snp_link;
    logic [DW-1:0] e_rd;
    @(negedge clk);
    req_valid = (op >= 0);
    req_op    = (op >= 0) ? op[1:0] : 2'd0;
    req_addr  = a[AW-1:0];
    req_wdata = wd;
    snp_v = sv; snp_a = sa[AW-1:0]; ctx = cx;
    #0.1;
    snp_link = sv && ((sa >> 2) == m_lt);
    pass = (op == 3) && (m_lv != 0) && ((a >> 2) == m_lt) && !cx && !snp_link;
    e_rv = (op == 0) || (op == 2) || (op == 3);
    e_rd = (op == 3) ? (pass ? 32'd0 : 32'd1) : mem[a[5:0]];
    e_we = (op == 1) || pass;
    if (op == 2) begin
      m_lv = !(cx || (sv && ((sa >> 2) == (a >> 2))));
      m_lt = a >> 2;
    end else if (op == 3 || cx || snp_link) m_lv = 0;
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== e_rv || (e_rv && rsp_rdata !== e_rd) || mem_we !== e_we ||
        (e_we && (mem_waddr !== a[AW-1:0] || mem_wdata !== wd))) begin
      fails++;
      $display("FAIL %s: rv=%0b rd=%0h we=%0b wa=%0h wd=%0h expected rv=%0b rd=%0h we=%0b wa=%0h wd=%0h",
               rq, rsp_valid, rsp_rdata, mem_we, mem_waddr, mem_wdata,
               e_rv, e_rd, e_we, a, wd);
    end
    req_valid = 1'b0; snp_v = 1'b0; ctx = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + i * 17;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0 || mem_we !== 1'b0) begin
      fails++;
      $display("FAIL R1: rv=%0b we=%0b expected 0 0", rsp_valid, mem_we);
    end
    @(negedge clk); rst_n = 1'b1;
    step("R1 sc after reset", 3, 8, 32'h11, 0, 0, 0);
    step("R2 load", 0, 5, 0, 0, 0, 0);
    step("R2 ll data", 2, 9, 0, 0, 0, 0);
    step("R3 sc pass", 3, 9, 32'hCAFE, 0, 0, 0);
    step("idle", -1, 0, 0, 0, 0, 0);
    step("R7 second sc", 3, 9, 32'hBEEF, 0, 0, 0);
    step("R3 sc other word same block", 2, 12, 0, 0, 0, 0);
    step("R3 sc pass word 14", 3, 14, 32'h1234, 0, 0, 0);
    step("R4 ll", 2, 20, 0, 0, 0, 0);
    step("R4 sc other block", 3, 24, 32'h55, 0, 0, 0);
    step("R7 after failed sc", 3, 20, 32'h56, 0, 0, 0);
    step("R5 ll", 2, 30, 0, 0, 0, 0);
    step("R5 ctx", -1, 0, 0, 0, 0, 1);
    step("R5 sc after ctx", 3, 30, 32'h77, 0, 0, 0);
    step("R6 ll", 2, 33, 0, 0, 0, 0);
    step("R6 snoop other block", -1, 0, 0, 1, 40, 0);
    step("R6 sc survives", 3, 33, 32'h88, 0, 0, 0);
    step("R6 ll again", 2, 33, 0, 0, 0, 0);
    step("R6 snoop other word", -1, 0, 0, 1, 35, 0);
    step("R6 sc after snoop", 3, 33, 32'h99, 0, 0, 0);
    step("R8 ll", 2, 44, 0, 0, 0, 0);
    step("R8 sc with snoop", 3, 44, 32'hAA, 1, 45, 0);
    step("R8 ll2", 2, 44, 0, 0, 0, 0);
    step("R8 sc with ctx", 3, 44, 32'hAB, 0, 0, 1);
    step("R8 ll with snoop", 2, 48, 0, 1, 50, 0);
    step("R8 sc after", 3, 48, 32'hAC, 0, 0, 0);
    step("R8 ll with ctx", 2, 48, 0, 0, 0, 1);
    step("R8 sc after ctx ll", 3, 48, 32'hAD, 0, 0, 0);
    step("R9 ll", 2, 52, 0, 0, 0, 0);
    step("R9 store", 1, 53, 32'h5151, 0, 0, 0);
    step("R9 load", 0, 60, 0, 0, 0, 0);
    step("idle", -1, 0, 0, 0, 0, 0);
    step("R9 readback", 0, 53, 0, 0, 0, 0);
    step("R9 sc after own ops", 3, 52, 32'h5252, 0, 0, 0);
    step("R10 ll a", 2, 4, 0, 0, 0, 0);
    step("R10 ll b", 2, 16, 0, 0, 0, 0);
    step("R10 sc old", 3, 4, 32'h61, 0, 0, 0);
    step("R10 ll b again", 2, 16, 0, 0, 0, 0);
    step("R10 sc new", 3, 17, 32'h62, 0, 0, 0);
    step("idle", -1, 0, 0, 0, 0, 0);
    step("R2 readback sc data", 0, 17, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule